// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received Ethernet frame should be kept, based on its destination address. The six destination-address bytes arrive one per accepted cycle on a byte stream. While they arrive, the block folds each byte into a running 32-bit CRC. It uses six bits of the final value to pick one bit of a 64-bit hash table, and that bit says whether the multicast group is wanted.

The hash table is written by the surrounding logic through four 16-bit registers. Three mode inputs shape the decision: promiscuous mode, all-multicast mode, and removal of the trailing frame check sequence. The unicast station-address match is computed outside the block and arrives on a single input. One clock after the sixth address byte, the block raises a one-cycle decision strobe together with the accept and strip results. A new-frame strobe starts the next address.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash CRC uses the reflected polynomial 0xEDB88320 and starts from all ones. Each byte is taken least-significant bit first. At each bit the CRC shifts right by one and is XORed with the polynomial when its old bit 0 differs from the data bit. No final inversion is applied. The table index is the low 6 CRC bits in reversed order: index bit 5 is CRC bit 0, and index bit 0 is CRC bit 5.
- R2: Index bits [5:3] choose a table byte and index bits [2:0] choose the bit inside it. Table register k (tbl_wr_sel = k, 0..3) is written when tbl_wr_en is 1. Its bits [7:0] hold table byte 2k and its bits [15:8] hold table byte 2k+1.
- R3: A frame is multicast when bit 0 of its first destination byte is 1. With no mode set, a multicast frame is accepted exactly when its table bit is 1.
- R4: With all_mcast set, every multicast frame is accepted whatever the table holds.
- R5: A destination of six 0xFF bytes (broadcast) is always accepted.
- R6: With promisc set, every frame is accepted.
- R7: Without promisc, a non-multicast frame is accepted exactly when station_hit is 1 in the decision cycle.
- R8: decision_valid is a one-cycle pulse in the cycle after the sixth address byte is taken. accept and strip_fcs are 0 whenever decision_valid is 0.
- R9: Address bytes after the sixth are ignored, and no further decision appears until the next frame_start.
- R10: frame_start restarts the CRC and the byte count. A byte presented in the same cycle as frame_start is the first byte of the new address.
- R11: strip_fcs is 1 in the decision cycle exactly when the frame is accepted and strip_cfg is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | New-frame strobe, restarts the address scan |
| addr_valid | input | 1 | addr_byte carries a destination byte this cycle |
| addr_byte | input | 8 | Destination address byte, first byte first |
| tbl_wr_en | input | 1 | Write one hash table register |
| tbl_wr_sel | input | 2 | Hash table register number |
| tbl_wr_data | input | 16 | Hash table register write value |
| promisc | input | 1 | Accept every frame |
| all_mcast | input | 1 | Accept every multicast frame |
| strip_cfg | input | 1 | Request removal of the frame check sequence from accepted frames |
| station_hit | input | 1 | External unicast station address match |
| decision_valid | output | 1 | Decision strobe |
| accept | output | 1 | Frame accepted |
| strip_fcs | output | 1 | Remove the 4-byte frame check sequence from this frame |

## Verification
The case that is hardest to reach from the ports is a multicast frame whose exact table bit decides the outcome. This matters most when that bit lies in the high half of a register, because only there does the byte ordering of the table writes show. The stimulus computes the hash index of each test address independently. It then loads a table that holds only that one bit, followed by the inverse table with every bit except that one. Over several addresses this walks indices in both halves of the registers. Restarts in the middle of an address and trailing bytes after the sixth are also driven, so that a stale CRC or a second decision shows up as a mismatch or as an unexpected strobe.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  // Fold one byte into a reflected CRC, LSB of the byte first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c_in,
                                                     input logic [7:0] d);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  output logic [CRC_W-1:0] crc_q,
  output logic             done_q,
  output logic             mcast_q,
  output logic             bcast_q
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, base_cnt;
  logic [CRC_W-1:0] crc_d, base_crc;
  logic             mcast_d, bcast_d, done_d, base_mc, base_bc, take;

  always_comb begin
    base_crc = restart ? CRC_SEED : crc_q;
    base_cnt = restart ? '0 : cnt_q;
    base_mc  = restart ? 1'b0 : mcast_q;
    base_bc  = restart ? 1'b1 : bcast_q;
    take     = byte_vld && (base_cnt < CNT_W'(ADDR_BYTES));

    crc_d   = take ? crc_fold_byte(base_crc, byte_in) : base_crc;
    cnt_d   = take ? base_cnt + 1'b1 : base_cnt;
    mcast_d = (take && base_cnt == '0) ? byte_in[0] : base_mc;
    bcast_d = take ? (base_bc & (&byte_in)) : base_bc;
    done_d  = take && (base_cnt == CNT_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q   <= CRC_SEED;
      cnt_q   <= '0;
      mcast_q <= 1'b0;
      bcast_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      crc_q   <= crc_d;
      cnt_q   <= cnt_d;
      mcast_q <= mcast_d;
      bcast_q <= bcast_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
  parameter int IDX_W = 6,
  parameter int REG_W = 16,
  localparam int TBL_BITS = 1 << IDX_W,
  localparam int NUM_REGS = TBL_BITS / REG_W,
  localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] idx,
  output logic             hit
);
  logic [TBL_BITS-1:0] flat;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [REG_W-1:0] reg_q;
    logic             reg_en;
    assign reg_en = wr_en && (wr_sel == SEL_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_q <= '0;
      else if (reg_en) reg_q <= wr_data;
    end
    // Low half is the lower-numbered table byte.
    assign flat[k*REG_W +: REG_W] = reg_q;
  end

  assign hit = flat[idx];
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide #(
  parameter int IDX_W = 6
) (
  input  logic             done,
  input  logic [IDX_W-1:0] crc_low,
  input  logic             mcast,
  input  logic             bcast,
  input  logic             tbl_hit,
  input  logic             promisc,
  input  logic             all_mcast,
  input  logic             station_hit,
  input  logic             strip_cfg,
  output logic [IDX_W-1:0] idx,
  output logic             accept,
  output logic             strip_fcs
);
  for (genvar j = 0; j < IDX_W; j++) begin : g_rev
    assign idx[IDX_W-1-j] = crc_low[j];
  end

  logic want;
  always_comb begin
    want = promisc | bcast | (mcast & (all_mcast | tbl_hit)) | (~mcast & station_hit);
    accept    = done & want;
    strip_fcs = done & want & strip_cfg;
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 6,
  parameter int REG_W      = 16,
  localparam int TBL_REGS  = (1 << IDX_W) / REG_W,
  localparam int TBL_SEL_W = (TBL_REGS > 1) ? $clog2(TBL_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 addr_valid,
  input  logic [7:0]           addr_byte,
  input  logic                 tbl_wr_en,
  input  logic [TBL_SEL_W-1:0] tbl_wr_sel,
  input  logic [REG_W-1:0]     tbl_wr_data,
  input  logic                 promisc,
  input  logic                 all_mcast,
  input  logic                 strip_cfg,
  input  logic                 station_hit,
  output logic                 decision_valid,
  output logic                 accept,
  output logic                 strip_fcs
);
  logic [CRC_W-1:0] crc_q;
  logic             frame_mcast, frame_bcast, tbl_hit;
  logic [IDX_W-1:0] hash_idx;

  mhf_crc_engine #(.ADDR_BYTES(ADDR_BYTES)) u_crc (
    .clk(clk), .rst_n(rst_n), .restart(frame_start), .byte_vld(addr_valid),
    .byte_in(addr_byte), .crc_q(crc_q), .done_q(decision_valid),
    .mcast_q(frame_mcast), .bcast_q(frame_bcast)
  );

  mhf_hash_table #(.IDX_W(IDX_W), .REG_W(REG_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_sel(tbl_wr_sel),
    .wr_data(tbl_wr_data), .idx(hash_idx), .hit(tbl_hit)
  );

  mhf_decide #(.IDX_W(IDX_W)) u_dec (
    .done(decision_valid), .crc_low(crc_q[IDX_W-1:0]), .mcast(frame_mcast),
    .bcast(frame_bcast), .tbl_hit(tbl_hit), .promisc(promisc),
    .all_mcast(all_mcast), .station_hit(station_hit), .strip_cfg(strip_cfg),
    .idx(hash_idx), .accept(accept), .strip_fcs(strip_fcs)
  );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker (
  input logic clk,
  input logic rst_n,
  input logic decision_valid,
  input logic accept,
  input logic strip_fcs,
  input logic promisc,
  input logic all_mcast,
  input logic station_hit,
  input logic frame_mcast,
  input logic frame_bcast
);
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |=> !decision_valid);
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !decision_valid |-> (!accept && !strip_fcs));
  p_promisc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && promisc) |-> accept);
  p_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && frame_bcast) |-> accept);
  p_allmc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && frame_mcast && all_mcast) |-> accept);
  p_unicast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && !frame_mcast && !promisc) |-> (accept == station_hit));
  p_strip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strip_fcs |-> accept);
endmodule

bind mcast_hash_filter mhf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .decision_valid(decision_valid), .accept(accept),
  .strip_fcs(strip_fcs), .promisc(promisc), .all_mcast(all_mcast),
  .station_hit(station_hit), .frame_mcast(frame_mcast), .frame_bcast(frame_bcast)
);

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, addr_valid = 1'b0;
  logic [7:0]  addr_byte = '0;
  logic        tbl_wr_en = 1'b0;
  logic [1:0]  tbl_wr_sel = '0;
  logic [15:0] tbl_wr_data = '0;
  logic        promisc = 1'b0, all_mcast = 1'b0, strip_cfg = 1'b0, station_hit = 1'b0;
  logic        decision_valid, accept, strip_fcs;

  int checks = 0;
  int errors = 0;
  logic [63:0] tbl_model = '0;

  typedef struct {
    logic  acc;
    logic  strip;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  mcast_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .addr_valid(addr_valid),
    .addr_byte(addr_byte), .tbl_wr_en(tbl_wr_en), .tbl_wr_sel(tbl_wr_sel),
    .tbl_wr_data(tbl_wr_data), .promisc(promisc), .all_mcast(all_mcast),
    .strip_cfg(strip_cfg), .station_hit(station_hit),
    .decision_valid(decision_valid), .accept(accept), .strip_fcs(strip_fcs)
  );

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic [5:0]  ix;
    logic        fb;
    c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ a[8*b+i];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    for (int j = 0; j < 6; j++) ix[5-j] = c[j];
    return ix;
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected decision per strobe.
  always @(negedge clk) begin
    if (rst_n && decision_valid) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 actual=unexpected decision expected=none");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, {accept, strip_fcs}, {e.acc, e.strip});
      end
    end
  end

  task automatic load_table(input logic [63:0] t);
    tbl_model = t;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_sel = 2'(k); tbl_wr_data = t[16*k +: 16];
    end
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // Driver: pushes the expected decision, then streams the address.
  task automatic send_frame(input logic [47:0] a, input int extra, input string tag);
    exp_t e;
    logic mc, bc, acc;
    mc  = a[0];
    bc  = &a;
    acc = promisc | bc | (mc & (all_mcast | tbl_model[ref_idx(a)])) | (!mc & station_hit);
    e.acc = acc; e.strip = acc & strip_cfg; e.tag = tag;
    sb_q.push_back(e);
    for (int b = 0; b < 6 + extra; b++) begin
      @(negedge clk);
      frame_start = (b == 0);
      addr_valid  = 1'b1;
      addr_byte   = (b < 6) ? a[8*b +: 8] : 8'(8'h3C + b);
    end
    @(negedge clk);
    frame_start = 1'b0; addr_valid = 1'b0;
    repeat (3) @(negedge clk);
    check({tag, " drained"}, 2'(sb_q.size()), 2'd0);
    check("R8 idle outputs", {accept, strip_fcs}, 2'b00);
  endtask

  task automatic send_partial(input logic [47:0] a, input int n);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      frame_start = (b == 0); addr_valid = 1'b1; addr_byte = a[8*b +: 8];
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] addrs [8];
    logic [5:0]  ix;
    addrs[0] = 48'h0000_5E00_0001; addrs[1] = 48'h1122_3344_5501;
    addrs[2] = 48'hFB00_005E_0001; addrs[3] = 48'h0100_0000_0033;
    addrs[4] = 48'hA5A5_A5A5_A5A7; addrs[5] = 48'h0000_0000_0001;
    addrs[6] = 48'h8080_8080_80C3; addrs[7] = 48'h0102_0304_0509;

    repeat (3) @(negedge clk);
    check("R8 reset", {decision_valid, accept}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: single-bit table hits and its complement misses.
    for (int n = 0; n < 8; n++) begin
      ix = ref_idx(addrs[n]);
      load_table(64'd1 << ix);
      send_frame(addrs[n], 0, "R1 R2 R3 single bit hit");
      load_table(~(64'd1 << ix));
      send_frame(addrs[n], 0, "R2 R3 complement miss");
    end

    // R4: all-multicast with an empty table.
    load_table('0);
    all_mcast = 1'b1;
    send_frame(addrs[1], 0, "R4 all multicast");
    all_mcast = 1'b0;
    send_frame(addrs[1], 0, "R3 empty table reject");

    // R5: broadcast with an empty table.
    send_frame(48'hFFFF_FFFF_FFFF, 0, "R5 broadcast");

    // R7: unicast follows station_hit.
    send_frame(48'h0A0B_0C0D_0E10, 0, "R7 unicast miss");
    station_hit = 1'b1;
    send_frame(48'h0A0B_0C0D_0E10, 0, "R7 unicast hit");
    station_hit = 1'b0;

    // R6: promiscuous.
    promisc = 1'b1;
    send_frame(48'h0A0B_0C0D_0E10, 0, "R6 promisc unicast");
    send_frame(addrs[2], 0, "R6 promisc multicast");
    promisc = 1'b0;

    // R11: strip only on accepted frames.
    strip_cfg = 1'b1;
    station_hit = 1'b1;
    send_frame(48'h2020_2020_2020, 0, "R11 strip accepted");
    station_hit = 1'b0;
    send_frame(48'h2020_2020_2020, 0, "R11 no strip rejected");
    strip_cfg = 1'b0;

    // R9: trailing bytes ignored, single decision.
    ix = ref_idx(addrs[3]);
    load_table(64'd1 << ix);
    send_frame(addrs[3], 5, "R9 trailing bytes ignored");

    // R10: abandoned partial address, then a restart.
    send_partial(48'hFFFF_FFFF_FFFF, 4);
    send_frame(addrs[3], 0, "R10 restart after partial");
    send_partial(addrs[3], 3);
    send_frame(addrs[4], 0, "R10 restart miss");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule